// File: doc/BRIEF.md
# Random single-input-change test pattern generator

This block is a built-in self-test stimulus source. It drives an N-bit vector into a circuit under test, and from one applied vector to the next exactly one input bit toggles. A K-bit maximal-length linear feedback shift register supplies the randomness. For each new vector the register is advanced by M shifts, where M = ceil(log2 N). The M freshly shifted-in bits name the position to toggle. A selection slice therefore never shares a bit with the slice used for the previous vector.

A session is run by a three-state controller. In IDLE (the only state that accepts a seed or a starting vector) raising `en` takes the START transition to RUN and captures the requested length. In RUN every cycle with `en` high presents one vector with `valid_o` high. When the final vector is consumed, the FINISH transition enters DONE, where `done_o` is high and the last vector is held. Dropping `en` in DONE takes the RELEASE transition back to IDLE. The generator state is kept across sessions, so a following session continues the same sequence.

For N that is not a power of two, a selection value s ≥ N is folded to s − N. At the default N = 8 no folding occurs.

Top module: `sic_pattern_gen`

## Requirements
- R1: After reset `vec_o` is 8'h00, `valid_o` and `done_o` are low, and the generator seed is 7'h01, which the first unloaded session uses.
- R2: Within a session, every valid vector after the first differs from the previous valid vector in exactly one bit.
- R3: The generator shifts left with feedback bit6 XOR bit5 (polynomial x^7+x^6+1) entering bit 0. It shifts 3 times per step. The selection s is bits [2:0] of the advanced state, and s toggles position x(s+1), where x1 is the MSB `vec_o[7]`.
- R4: A seed loaded in IDLE replaces the generator state, and a zero seed is replaced by 7'h01.
- R5: A starting vector loaded in IDLE is the first vector presented by the next session.
- R6: The programmed length is clamped to the range 1..254 (a value of 0 gives 1, and values above 254 give 254). `valid_o` is high for exactly that many `en` cycles in the session.
- R7: After the last valid vector, `done_o` is high, `valid_o` is low and `vec_o` holds the last vector. `done_o` falls one cycle after `en` is dropped.
- R8: While `en` is low in RUN, `valid_o` is low, the vector and generator hold, and the cycle is not counted.
- R9: Seed and vector loads asserted outside IDLE have no effect.
- R10: Across back-to-back sessions, the vector after 127 further toggles differs from the current one only in x1, and after 254 toggles it is identical.
- R11: Over 254 consecutive toggles, each of the 8 positions is toggled between 24 and 40 times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Starts a session in IDLE, gates stepping in RUN, releases DONE when low |
| seed_load | input | 1 | Load `seed_in` into the generator (IDLE only) |
| seed_in | input | K | Generator seed |
| init_load | input | 1 | Load `init_vec` as the starting vector (IDLE only) |
| init_vec | input | N | Starting vector |
| len_in | input | K+1 | Requested number of vectors, captured on START |
| vec_o | output | N | Test vector to the circuit under test |
| valid_o | output | 1 | Current vector is applied and counted this cycle |
| done_o | output | 1 | Session finished, vector held |

## Verification
`valid_o` and `done_o` are decoded from the state register and from `en`. The bench therefore changes `en` on a falling edge and samples them 1 ns later, in the same half cycle. A vector counted at a rising edge is replaced by its successor at that same edge. The bench compares every valid vector against its own reference model, advanced once per consumed vector. It expects `done_o` one cycle after the last valid vector and an IDLE state one cycle after `en` drops. Loads and pauses are placed on falling edges, so the next rising edge alone decides whether they take effect.

// File: rtl/sic_gen_pkg.sv
package sic_gen_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } sess_state_t;
endpackage

// File: rtl/sic_lfsr.sv
module sic_lfsr #(
    parameter int K = 7,
    parameter int M = 3,
    parameter logic [K-1:0] TAPS = 7'b1100000,
    parameter logic [K-1:0] SEED_DEFAULT = 7'h01
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [K-1:0] seed,
    input  logic         step,
    output logic [K-1:0] state_o,
    output logic [M-1:0] slice_o
);
    logic [K-1:0] st_q;
    logic [K-1:0] st_adv;

    // M single shifts per step: the low M bits are all new
    always_comb begin
        st_adv = st_q;
        for (int i = 0; i < M; i++) begin
            st_adv = {st_adv[K-2:0], ^(st_adv & TAPS)};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SEED_DEFAULT;
        end else if (load) begin
            st_q <= (seed == '0) ? SEED_DEFAULT : seed;
        end else if (step) begin
            st_q <= st_adv;
        end
    end

    assign state_o = st_q;
    assign slice_o = st_adv[M-1:0];
endmodule

// File: rtl/sic_flip_decode.sv
module sic_flip_decode #(
    parameter int N = 8,
    parameter int M = 3
) (
    input  logic [M-1:0] sel,
    output logic [N-1:0] mask
);
    localparam bit          POW2 = ((1 << M) == N);
    localparam logic [M:0]  NV   = (M+1)'(N);

    logic [M:0] idx;

    generate
        if (POW2) begin : g_direct
            assign idx = {1'b0, sel};
        end else begin : g_fold
            assign idx = ({1'b0, sel} >= NV) ? ({1'b0, sel} - NV) : {1'b0, sel};
        end
    endgenerate

    // position 0 is x1, the most significant bit
    generate
        for (genvar b = 0; b < N; b++) begin : g_mask
            assign mask[N-1-b] = (idx == (M+1)'(b));
        end
    endgenerate
endmodule

// File: rtl/sic_session_ctrl.sv
module sic_session_ctrl
    import sic_gen_pkg::*;
#(
    parameter int K  = 7,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [LW-1:0] len_in,
    output logic          valid_o,
    output logic          done_o,
    output logic          step_o,
    output logic          load_ok_o
);
    localparam int          PERIOD = 2 * ((1 << K) - 1);
    localparam logic [LW-1:0] PER  = LW'(PERIOD);

    sess_state_t   state, state_nx;
    logic [LW-1:0] cnt, len_q, len_clamp;
    logic          last;

    always_comb begin
        if (len_in == '0)      len_clamp = LW'(1);
        else if (len_in > PER) len_clamp = PER;
        else                   len_clamp = len_in;
    end

    assign last = (cnt == len_q - LW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            len_q <= LW'(1);
        end else if (state == S_IDLE && en) begin
            cnt   <= '0;
            len_q <= len_clamp;
        end else if (step_o) begin
            cnt   <= cnt + LW'(1);
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (en)         state_nx = S_RUN;
            S_RUN:   if (en && last) state_nx = S_DONE;
            S_DONE:  if (!en)        state_nx = S_IDLE;
            default:                 state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        valid_o   = 1'b0;
        done_o    = 1'b0;
        step_o    = 1'b0;
        load_ok_o = 1'b0;
        unique case (state)
            S_IDLE: load_ok_o = 1'b1;
            S_RUN: begin
                valid_o = en;
                step_o  = en && !last;
            end
            S_DONE:  done_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/sic_pattern_gen.sv
module sic_pattern_gen #(
    parameter int N = 8,
    parameter int K = 7,
    parameter logic [K-1:0] TAPS = 7'b1100000,
    parameter logic [K-1:0] SEED_DEFAULT = 7'h01,
    parameter logic [N-1:0] INIT_DEFAULT = '0,
    localparam int LW = K + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          seed_load,
    input  logic [K-1:0]  seed_in,
    input  logic          init_load,
    input  logic [N-1:0]  init_vec,
    input  logic [LW-1:0] len_in,
    output logic [N-1:0]  vec_o,
    output logic          valid_o,
    output logic          done_o
);
    localparam int M = (N > 1) ? $clog2(N) : 1;

    logic         step, load_ok;
    logic [K-1:0] lfsr_state;
    logic [M-1:0] sel;
    logic [N-1:0] mask;
    logic [N-1:0] vec_q;

    sic_session_ctrl #(.K(K), .LW(LW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .len_in(len_in),
        .valid_o(valid_o), .done_o(done_o), .step_o(step), .load_ok_o(load_ok)
    );

    sic_lfsr #(.K(K), .M(M), .TAPS(TAPS), .SEED_DEFAULT(SEED_DEFAULT)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .load(load_ok && seed_load), .seed(seed_in),
        .step(step), .state_o(lfsr_state), .slice_o(sel)
    );

    sic_flip_decode #(.N(N), .M(M)) u_dec (
        .sel(sel), .mask(mask)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= INIT_DEFAULT;
        end else if (load_ok && init_load) begin
            vec_q <= init_vec;
        end else if (step) begin
            vec_q <= vec_q ^ mask;
        end
    end

    assign vec_o = vec_q;
endmodule

// File: rtl/sic_pattern_gen_chk.sv
module sic_pattern_gen_chk #(
    parameter int N = 8,
    parameter int K = 7
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en,
    input logic [N-1:0] vec_o,
    input logic         valid_o,
    input logic         done_o,
    input logic [K-1:0] lfsr_state
);
    localparam int PERIOD = 2 * ((1 << K) - 1);

    logic [K+1:0] vcnt;

    always_ff @(posedge clk) begin
        if (!rst_n)       vcnt <= '0;
        else if (done_o)  vcnt <= '0;
        else if (valid_o) vcnt <= vcnt + 1'b1;
    end

    AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o)) |-> ($countones(vec_o ^ $past(vec_o)) == 1)); // R2

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(done_o)) |-> $stable(vec_o)); // R7

    AST_NO_VALID_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !valid_o); // R7

    AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !valid_o); // R8

    AST_SEED_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_state != '0); // R4

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        vcnt <= (K+2)'(PERIOD)); // R6
endmodule

bind sic_pattern_gen sic_pattern_gen_chk #(.N(N), .K(K)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .vec_o(vec_o), .valid_o(valid_o),
    .done_o(done_o), .lfsr_state(lfsr_state)
);

// File: tb/sic_pattern_gen_test.sv
module sic_pattern_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       seed_load = 1'b0;
    logic [6:0] seed_in = '0;
    logic       init_load = 1'b0;
    logic [7:0] init_vec = '0;
    logic [7:0] len_in = '0;
    logic [7:0] vec_o;
    logic       valid_o, done_o;

    int total = 0, fails = 0;
    bit finished = 1'b0;

    logic [6:0] ms = 7'h01;   // reference generator state
    logic [7:0] mv = 8'h00;   // reference vector
    logic [7:0] h [0:511];
    int         hcnt = 0;

    sic_pattern_gen uut (
        .clk(clk), .rst_n(rst_n), .en(en), .seed_load(seed_load), .seed_in(seed_in),
        .init_load(init_load), .init_vec(init_vec), .len_in(len_in),
        .vec_o(vec_o), .valid_o(valid_o), .done_o(done_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] madv(input logic [6:0] s);
        logic [6:0] t = s;
        for (int i = 0; i < 3; i++) t = {t[5:0], t[6] ^ t[5]};
        return t;
    endfunction

    task automatic mstep();
        ms = madv(ms);
        mv[7 - ms[2:0]] = ~mv[7 - ms[2:0]];
    endtask

    // seed, init, len, expected count, pause index, in-run load index
    localparam logic [6:0] T_SEED [5] = '{7'h01, 7'h5A, 7'h00, 7'h33, 7'h6E};
    localparam logic [7:0] T_INIT [5] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81};
    localparam logic [7:0] T_LEN  [5] = '{8'd10, 8'd1, 8'd6, 8'd0, 8'd255};
    localparam int         T_EXP  [5] = '{10, 1, 6, 1, 254};
    localparam int         T_PAUS [5] = '{4, -1, -1, -1, 100};
    localparam int         T_LDAT [5] = '{-1, -1, 2, -1, 200};

    task automatic run_session(input bit doload, input logic [6:0] sd, input logic [7:0] iv,
                               input logic [7:0] ln, input int explen, input int pause_at,
                               input int load_at, input bit rec);
        logic [7:0] prev = '0;
        if (doload) begin
            @(negedge clk);
            seed_in = sd; init_vec = iv; seed_load = 1'b1; init_load = 1'b1;
            ms = (sd == 7'h00) ? 7'h01 : sd;
            mv = iv;
        end
        @(negedge clk);
        seed_load = 1'b0; init_load = 1'b0;
        len_in = ln; en = 1'b1;
        for (int i = 0; i < explen; i++) begin
            @(negedge clk);
            seed_load = 1'b0; init_load = 1'b0;
            if (i == pause_at) begin
                en = 1'b0;
                #1;
                chk(!valid_o && vec_o == mv, "R8", {valid_o, vec_o}, {1'b0, mv});
                @(negedge clk);
                chk(vec_o == mv, "R8", vec_o, mv);
                en = 1'b1;
            end
            if (i == load_at) begin
                seed_in = 7'h7F; init_vec = ~mv; seed_load = 1'b1; init_load = 1'b1;
            end
            #1;
            chk(valid_o == 1'b1, "R6", valid_o, 1);
            chk(vec_o == mv, (i == 0) ? "R5" : "R3", vec_o, mv);
            if (i > 0) chk($countones(vec_o ^ prev) == 1, "R2", vec_o ^ prev, 1);
            if (i > load_at && load_at >= 0) chk(vec_o == mv, "R9", vec_o, mv);
            prev = vec_o;
            if (rec && hcnt < 512) begin h[hcnt] = vec_o; hcnt++; end
            if (i < explen - 1) mstep();
        end
        @(negedge clk);
        seed_load = 1'b0; init_load = 1'b0;
        #1;
        chk(done_o && !valid_o, "R6", {done_o, valid_o}, 2'b10);
        chk(vec_o == mv, "R7", vec_o, mv);
        @(negedge clk);
        #1;
        chk(done_o && vec_o == mv, "R7", {done_o, vec_o}, {1'b1, mv});
        en = 1'b0;
        @(negedge clk);
        #1;
        chk(!done_o && !valid_o, "R7", {done_o, valid_o}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(vec_o == 8'h00 && !valid_o && !done_o, "R1", {valid_o, done_o, vec_o}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(vec_o == 8'h00 && !valid_o && !done_o, "R1", {valid_o, done_o, vec_o}, 0);
        // default seed after reset, no loads
        ms = 7'h01; mv = 8'h00;
        run_session(1'b0, 7'h00, 8'h00, 8'd3, 3, -1, -1, 1'b0);

        for (int t = 0; t < 5; t++) begin
            run_session(1'b1, T_SEED[t], T_INIT[t], T_LEN[t], T_EXP[t], T_PAUS[t], T_LDAT[t], 1'b0);
        end

        // R10 / R11: two full-length sessions back to back
        hcnt = 0;
        run_session(1'b1, 7'h01, 8'h00, 8'd254, 254, -1, -1, 1'b1);
        run_session(1'b0, 7'h00, 8'h00, 8'd254, 254, -1, -1, 1'b1);
        // second session starts with the held vector: skip h[254]
        begin
            int bad_half = 0, bad_full = 0;
            int cnt_pos [8];
            for (int p = 0; p < 8; p++) cnt_pos[p] = 0;
            for (int i = 0; i <= 126; i++)
                if ((h[i] ^ h[i + 127]) != 8'h80) bad_half++;
            for (int i = 0; i <= 252; i++)
                if (h[i] != h[i + 255]) bad_full++;
            chk(bad_half == 0, "R10", bad_half, 0);
            chk(bad_full == 0, "R10", bad_full, 0);
            for (int i = 0; i < 253; i++)
                for (int p = 0; p < 8; p++)
                    if (h[i][p] != h[i + 1][p]) cnt_pos[p]++;
            for (int p = 0; p < 8; p++)
                if (h[253][p] != h[255][p]) cnt_pos[p]++;
            for (int p = 0; p < 8; p++)
                chk(cnt_pos[p] >= 24 && cnt_pos[p] <= 40, "R11", cnt_pos[p], 32);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule